// File: doc/BRIEF.md
# Fuse array read sequencer

This block copies a range of bytes out of a one-time-programmable fuse macro into a local byte buffer. A single start pulse supplies the first fuse address, the number of bytes, and whether the macro's burst-read mode should be on. The block powers the macro up in a fixed order with a timed settle gap. It then reads the addresses one at a time, each through a request and ready handshake with a bounded wait. At the end it powers the macro back down in the reverse order.

Each read places the address on the control port with a one-cycle request pulse. The macro drops its ready flag on that request and raises it again with the byte in the low eight bits of its status word. The sequencer writes every byte it receives into the buffer at that byte's offset within the range. If the ready flag stays low for longer than the timeout, the rest of the range is abandoned, the error flag is raised, and the normal power-down still runs. A byte count of zero finishes at once, without touching power or the array.

Top module: `fuse_rd_seq`

## Requirements
- R1: During and right after reset, both power enables, burst, request, buffer strobe, done and error are 0, and the isolation output is 1.
- R2: A start with a non-zero count raises the first power enable at the sampling edge. The second power enable rises exactly SETTLE_CYC cycles later, and isolation is released one cycle after that.
- R3: The burst output takes the burst request captured at start one cycle after isolation is released. It returns to 0 as the first step of power-down, one cycle before isolation is re-asserted.
- R4: Each byte is fetched with a request pulse one cycle wide, while the address output holds start address plus byte offset, wrapping modulo 2^ADDR_W. Addresses run in ascending order. The ready input is ignored in the cycle right after the request.
- R5: When ready is seen, a one-cycle buffer strobe is issued in the next cycle with buffer address equal to the byte offset (0 for the first byte) and buffer data equal to the low 8 bits of the status input. The next request follows one cycle after the strobe.
- R6: If ready is not seen within TIMEOUT_CYC waiting cycles (a read latency of TIMEOUT_CYC or more), the error flag is set in the last waiting cycle. No further request or strobe is issued for that run, and power-down follows.
- R7: Power-down re-asserts isolation, drops the second power enable one cycle later, and drops the first power enable SETTLE_CYC cycles after that. The done pulse comes in the same cycle as the first power enable drops.
- R8: A start with a byte count of 0 gives a one-cycle done pulse at the sampling edge. It raises no power enable and issues no request.
- R9: A start pulse that arrives while a run is in progress has no effect on that run's outputs or timing.
- R10: The error flag holds its value between runs and is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| start_addr_i | input | ADDR_W | First fuse address of the range |
| byte_cnt_i | input | CNT_W | Number of bytes to read |
| burst_en_i | input | 1 | Turn on burst-read mode for this run |
| pwr_a_o | output | 1 | First power enable of the fuse macro |
| pwr_b_o | output | 1 | Second power enable of the fuse macro |
| iso_o | output | 1 | Isolation between macro and core (1 = isolated) |
| burst_o | output | 1 | Burst-read mode enable |
| fuse_req_o | output | 1 | Control write: address valid, ready cleared |
| fuse_addr_o | output | ADDR_W | Fuse address field |
| fuse_rdy_i | input | 1 | Ready flag of the status word |
| fuse_data_i | input | DATA_W | Low byte of the status word |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | CNT_W | Buffer byte offset |
| buf_data_o | output | DATA_W | Buffer write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout error flag |

## Verification
A wrong state in the sequencing logic shows up first on the power and isolation pins. A skipped or repeated settle state moves the second power enable or the first enable's release by at least one cycle, and the every-cycle comparison catches that at once. A wrong byte offset or address step appears on the request address or buffer address at the very next request or strobe. A timeout counter that is not cleared, or is off by one, shows in the boundary runs: a latency one below the limit must succeed, and a latency equal to the limit must set the error flag in a known cycle. A start taken while busy disturbs the power pins within the settle interval.

// File: rtl/fuse_seq_pkg.sv
// Package: shared state encoding for the fuse read sequencer.
// Assumes: nothing beyond a 4-bit state register.
package fuse_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_SETTLE_UP = 4'd1,
        ST_ISO_REL   = 4'd2,
        ST_BURST_ON  = 4'd3,
        ST_ISSUE     = 4'd4,
        ST_CLEAR     = 4'd5,
        ST_WAIT      = 4'd6,
        ST_BURST_OFF = 4'd7,
        ST_ISO_ON    = 4'd8,
        ST_PWRB_OFF  = 4'd9,
        ST_SETTLE_DN = 4'd10
    } seq_state_e;

endpackage

// File: rtl/fuse_seq_timer.sv
// Module: up-counting interval timer.
// Counts cycles while run_i is high and returns to zero while clear_i is high.
// last_o marks the LIMIT-th running cycle since the last clear.
// Assumes: LIMIT >= 1; clear_i and run_i are never high together.
module fuse_seq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic last_o
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    // Cycle counter: cleared outside the timed state, advances inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry flag for the current running cycle.
    always_comb begin
        last_o = run_i && (cnt_q == LAST_VAL);
    end
endmodule

// File: rtl/fuse_seq_addr.sv
// Module: address and byte-offset generator for one read run.
// It loads the start address and the final offset on load_i and moves both on step_i.
// Assumes: load_i is issued only with a non-zero count.
module fuse_seq_addr #(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  idx_o,
    output logic              last_o,
    output logic              cnt_zero_o
);
    logic [CNT_W-1:0] last_idx_q;

    // Address, offset and final offset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_o <= '0;
            idx_o      <= '0;
            last_idx_q <= '0;
        end else if (load_i) begin
            cur_addr_o <= start_addr_i;
            idx_o      <= '0;
            last_idx_q <= byte_cnt_i - 1'b1;
        end else if (step_i) begin
            cur_addr_o <= cur_addr_o + 1'b1;
            idx_o      <= idx_o + 1'b1;
        end
    end

    // Range decode for the controller.
    always_comb begin
        last_o     = (idx_o == last_idx_q);
        cnt_zero_o = (byte_cnt_i == '0);
    end
endmodule

// File: rtl/fuse_seq_ctrl.sv
// Module: sequencing state machine for the fuse read.
// It drives power, isolation and burst in order, issues requests, captures bytes
// and reports done and error. Every output is a register.
// Assumes: the timers and address generator are wired as in fuse_rd_seq.
module fuse_seq_ctrl
    import fuse_seq_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              burst_en_i,
    input  logic              cnt_zero_i,
    input  logic              settle_last_i,
    input  logic              wait_last_i,
    input  logic              last_byte_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  logic              fuse_rdy_i,
    input  logic [DATA_W-1:0] fuse_data_i,
    output seq_state_e        state_o,
    output logic              load_o,
    output logic              step_o,
    output logic              pwr_a_o,
    output logic              pwr_b_o,
    output logic              iso_o,
    output logic              burst_o,
    output logic              fuse_req_o,
    output logic [ADDR_W-1:0] fuse_addr_o,
    output logic              buf_we_o,
    output logic [CNT_W-1:0]  buf_addr_o,
    output logic [DATA_W-1:0] buf_data_o,
    output logic              done_o,
    output logic              err_o
);
    seq_state_e st_q;
    logic       burst_cfg_q;

    // Load and step strobes for the address generator.
    always_comb begin
        load_o  = (st_q == ST_IDLE) && start_i && !cnt_zero_i;
        step_o  = (st_q == ST_WAIT) && fuse_rdy_i && !last_byte_i;
        state_o = st_q;
    end

    // Main sequencer: state, power pins and the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            burst_cfg_q <= 1'b0;
            pwr_a_o     <= 1'b0;
            pwr_b_o     <= 1'b0;
            iso_o       <= 1'b1;
            burst_o     <= 1'b0;
            fuse_req_o  <= 1'b0;
            fuse_addr_o <= '0;
            buf_we_o    <= 1'b0;
            buf_addr_o  <= '0;
            buf_data_o  <= '0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            fuse_req_o <= 1'b0;
            buf_we_o   <= 1'b0;
            done_o     <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        err_o <= 1'b0;
                        if (cnt_zero_i) begin
                            done_o <= 1'b1;
                        end else begin
                            pwr_a_o     <= 1'b1;
                            burst_cfg_q <= burst_en_i;
                            st_q        <= ST_SETTLE_UP;
                        end
                    end
                end
                ST_SETTLE_UP: begin
                    if (settle_last_i) begin
                        pwr_b_o <= 1'b1;
                        st_q    <= ST_ISO_REL;
                    end
                end
                ST_ISO_REL: begin
                    iso_o <= 1'b0;
                    st_q  <= ST_BURST_ON;
                end
                ST_BURST_ON: begin
                    burst_o <= burst_cfg_q;
                    st_q    <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    fuse_req_o  <= 1'b1;
                    fuse_addr_o <= cur_addr_i;
                    st_q        <= ST_CLEAR;
                end
                ST_CLEAR: begin
                    st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (fuse_rdy_i) begin
                        buf_we_o   <= 1'b1;
                        buf_addr_o <= idx_i;
                        buf_data_o <= fuse_data_i;
                        st_q       <= last_byte_i ? ST_BURST_OFF : ST_ISSUE;
                    end else if (wait_last_i) begin
                        err_o <= 1'b1;
                        st_q  <= ST_BURST_OFF;
                    end
                end
                ST_BURST_OFF: begin
                    burst_o <= 1'b0;
                    st_q    <= ST_ISO_ON;
                end
                ST_ISO_ON: begin
                    iso_o <= 1'b1;
                    st_q  <= ST_PWRB_OFF;
                end
                ST_PWRB_OFF: begin
                    pwr_b_o <= 1'b0;
                    st_q    <= ST_SETTLE_DN;
                end
                ST_SETTLE_DN: begin
                    if (settle_last_i) begin
                        pwr_a_o <= 1'b0;
                        done_o  <= 1'b1;
                        st_q    <= ST_IDLE;
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/fuse_rd_seq.sv
// Module: top of the fuse array read sequencer.
// It joins the state machine, the settle timer, the ready-timeout timer and the
// address generator.
// Assumes: the fuse macro clears ready on a request and raises it at least one
// cycle later with the byte on fuse_data_i.
module fuse_rd_seq
    import fuse_seq_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int CNT_W       = 8,
    parameter int DATA_W      = 8,
    parameter int SETTLE_CYC  = 16,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic              burst_en_i,
    output logic              pwr_a_o,
    output logic              pwr_b_o,
    output logic              iso_o,
    output logic              burst_o,
    output logic              fuse_req_o,
    output logic [ADDR_W-1:0] fuse_addr_o,
    input  logic              fuse_rdy_i,
    input  logic [DATA_W-1:0] fuse_data_i,
    output logic              buf_we_o,
    output logic [CNT_W-1:0]  buf_addr_o,
    output logic [DATA_W-1:0] buf_data_o,
    output logic              done_o,
    output logic              err_o
);
    seq_state_e        state;
    logic              load, step_en;
    logic              settle_run, settle_last;
    logic              wait_run, wait_last;
    logic              last_byte, cnt_zero;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  idx;

    // Timer enables decoded from the sequencer state.
    always_comb begin
        settle_run = (state == ST_SETTLE_UP) || (state == ST_SETTLE_DN);
        wait_run   = (state == ST_WAIT);
    end

    fuse_seq_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!settle_run),
        .run_i   (settle_run),
        .last_o  (settle_last)
    );

    fuse_seq_timer #(.LIMIT(TIMEOUT_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!wait_run),
        .run_i   (wait_run),
        .last_o  (wait_last)
    );

    fuse_seq_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .step_i       (step_en),
        .start_addr_i (start_addr_i),
        .byte_cnt_i   (byte_cnt_i),
        .cur_addr_o   (cur_addr),
        .idx_o        (idx),
        .last_o       (last_byte),
        .cnt_zero_o   (cnt_zero)
    );

    fuse_seq_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .burst_en_i    (burst_en_i),
        .cnt_zero_i    (cnt_zero),
        .settle_last_i (settle_last),
        .wait_last_i   (wait_last),
        .last_byte_i   (last_byte),
        .cur_addr_i    (cur_addr),
        .idx_i         (idx),
        .fuse_rdy_i    (fuse_rdy_i),
        .fuse_data_i   (fuse_data_i),
        .state_o       (state),
        .load_o        (load),
        .step_o        (step_en),
        .pwr_a_o       (pwr_a_o),
        .pwr_b_o       (pwr_b_o),
        .iso_o         (iso_o),
        .burst_o       (burst_o),
        .fuse_req_o    (fuse_req_o),
        .fuse_addr_o   (fuse_addr_o),
        .buf_we_o      (buf_we_o),
        .buf_addr_o    (buf_addr_o),
        .buf_data_o    (buf_data_o),
        .done_o        (done_o),
        .err_o         (err_o)
    );
endmodule

// File: rtl/fuse_rd_seq_chk.sv
// Module: protocol checker for fuse_rd_seq, attached by bind.
// It observes the top-level ports only.
// Assumes: synchronous active-low reset on rst_n.
module fuse_rd_seq_chk #(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_a_o,
    input logic              pwr_b_o,
    input logic              iso_o,
    input logic              burst_o,
    input logic              fuse_req_o,
    input logic [ADDR_W-1:0] fuse_addr_o,
    input logic              buf_we_o,
    input logic [CNT_W-1:0]  buf_addr_o,
    input logic              done_o,
    input logic              err_o
);
    // R2: the second enable only rises on top of the first, while still isolated.
    assert_pwrb_on_pwra_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_b_o) |-> (pwr_a_o && iso_o));

    // R2: isolation is only released with both enables on.
    assert_iso_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_o) |-> (pwr_a_o && pwr_b_o));

    // R3: burst mode is on only while isolation is released.
    assert_burst_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o |-> !iso_o);

    // R4: a request lasts a single cycle.
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req_o |=> !fuse_req_o);

    // R4: requests happen only with the macro fully powered and not isolated.
    assert_req_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_req_o |-> (pwr_a_o && pwr_b_o && !iso_o));

    // R5: a buffer strobe never coincides with a request.
    assert_we_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |-> !fuse_req_o);

    // R6: the error flag never rises together with a buffer strobe.
    assert_err_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !buf_we_o);

    // R7: the second enable drops only after isolation is back.
    assert_pwrb_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_b_o) |-> (iso_o && !burst_o));

    // R7: the first enable drops last, together with the done pulse.
    assert_pwra_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_a_o) |-> (!pwr_b_o && done_o));

    // R8: done is a single-cycle pulse.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_a_o     (pwr_a_o),
    .pwr_b_o     (pwr_b_o),
    .iso_o       (iso_o),
    .burst_o     (burst_o),
    .fuse_req_o  (fuse_req_o),
    .fuse_addr_o (fuse_addr_o),
    .buf_we_o    (buf_we_o),
    .buf_addr_o  (buf_addr_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/tb_fuse_rd_seq.sv
`timescale 1ns/1ps
// Bench: a behavioural fuse macro model plus a cycle-by-cycle expected-output
// model, compared with the design on every falling clock edge.
module tb_fuse_rd_seq;
    localparam int AW  = 11;
    localparam int CW  = 8;
    localparam int DW  = 8;
    localparam int S   = 3;
    localparam int TMO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [CW-1:0] byte_cnt_i = '0;
    logic          burst_en_i = 1'b0;
    logic          pwr_a_o, pwr_b_o, iso_o, burst_o, fuse_req_o;
    logic [AW-1:0] fuse_addr_o;
    logic          fuse_rdy;
    logic [DW-1:0] fuse_data;
    logic          buf_we_o;
    logic [CW-1:0] buf_addr_o;
    logic [DW-1:0] buf_data_o;
    logic          done_o, err_o;

    fuse_rd_seq #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW),
                  .SETTLE_CYC(S), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .byte_cnt_i(byte_cnt_i), .burst_en_i(burst_en_i), .pwr_a_o(pwr_a_o),
        .pwr_b_o(pwr_b_o), .iso_o(iso_o), .burst_o(burst_o), .fuse_req_o(fuse_req_o),
        .fuse_addr_o(fuse_addr_o), .fuse_rdy_i(fuse_rdy), .fuse_data_i(fuse_data),
        .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o),
        .done_o(done_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    int lat = 1;
    int lcnt = 0;
    int wr_cnt = 0;
    bit acc_seen = 0;
    bit cmp_en = 0;
    bit finished = 0;
    string cur_tag = "R1";
    logic [AW-1:0] lat_addr;

    function automatic logic [DW-1:0] fmem(input int a);
        return DW'(((a % (1 << AW)) * 37 + 11) & 8'hff);
    endfunction

    // Fuse macro model: request clears ready, byte appears lat cycles later.
    always @(posedge clk) begin
        if (!rst_n) begin
            fuse_rdy  <= 1'b1;
            fuse_data <= 8'hA5;
            lcnt      <= 0;
        end else if (fuse_req_o) begin
            fuse_rdy <= 1'b0;
            lcnt     <= lat;
            lat_addr <= fuse_addr_o;
        end else if (lcnt > 0) begin
            lcnt <= lcnt - 1;
            if (lcnt == 1) begin
                fuse_rdy  <= 1'b1;
                fuse_data <= fmem(int'(lat_addr));
            end
        end
    end

    // Activity monitors for the count-based checks.
    always @(posedge clk) begin
        if (buf_we_o) wr_cnt++;
        if (pwr_a_o || fuse_req_o) acc_seen = 1;
    end

    // Expected outputs.
    logic          e_pa = 0, e_pb = 0, e_iso = 1, e_burst = 0, e_req = 0, e_we = 0;
    logic          e_done = 0, e_err = 0;
    logic [AW-1:0] e_faddr = '0;
    logic [CW-1:0] e_baddr = '0;
    logic [DW-1:0] e_bdata = '0;

    task automatic cmp(input string sig, input string rq, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h at cycle %0d",
                     rq, cur_tag, sig, act, exp, cycles);
        end
    endtask

    // Every-cycle comparison against the expected model.
    always @(negedge clk) begin
        cycles++;
        if (cmp_en) begin
            vectors++;
            cmp("pwr_a", "R2/R7", int'(pwr_a_o), int'(e_pa));
            cmp("pwr_b", "R2/R7", int'(pwr_b_o), int'(e_pb));
            cmp("iso", "R2/R7", int'(iso_o), int'(e_iso));
            cmp("burst", "R3", int'(burst_o), int'(e_burst));
            cmp("req", "R4", int'(fuse_req_o), int'(e_req));
            cmp("faddr", "R4", int'(fuse_addr_o), int'(e_faddr));
            cmp("we", "R5", int'(buf_we_o), int'(e_we));
            cmp("baddr", "R5", int'(buf_addr_o), int'(e_baddr));
            cmp("bdata", "R5", int'(buf_data_o), int'(e_bdata));
            cmp("done", "R7/R8", int'(done_o), int'(e_done));
            cmp("err", "R6/R10", int'(err_o), int'(e_err));
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #50000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic step();
        @(posedge clk);
        #1;
        e_req  = 0;
        e_we   = 0;
        e_done = 0;
    endtask

    // One run: drive a start, then advance the expected model edge by edge.
    task automatic run(input int a, input int n, input bit b, input int l,
                       input bit poke, input string tag);
        int exp_wr;
        cur_tag = tag;
        lat = l;
        @(negedge clk);
        start_i = 1; start_addr_i = AW'(a); byte_cnt_i = CW'(n); burst_en_i = b;
        @(posedge clk);
        #1;
        start_i = 0;
        wr_cnt = 0; acc_seen = 0;
        e_req = 0; e_we = 0; e_done = 0; e_err = 0;
        exp_wr = 0;
        if (n == 0) begin
            e_done = 1;
            step();
        end else begin
            e_pa = 1;
            if (poke) begin
                start_i = 1; start_addr_i = AW'(a + 5); byte_cnt_i = '0; burst_en_i = !b;
            end
            for (int k = 0; k < S - 1; k++) begin
                step();
                start_i = 0;
            end
            step(); e_pb = 1;
            step(); e_iso = 0;
            step(); e_burst = b;
            for (int i = 0; i < n; i++) begin
                step(); e_req = 1; e_faddr = AW'(a + i);
                step();
                if (l < TMO) begin
                    repeat (l) step();
                    step(); e_we = 1; e_baddr = CW'(i); e_bdata = fmem(a + i);
                    exp_wr++;
                end else begin
                    repeat (TMO - 1) step();
                    step(); e_err = 1;
                    break;
                end
            end
            step(); e_burst = 0;
            step(); e_iso = 1;
            step(); e_pb = 0;
            repeat (S - 1) step();
            step(); e_pa = 0; e_done = 1;
            step();
        end
        repeat (3) step();
        vectors++;
        if (wr_cnt != exp_wr) begin
            miscompares++;
            $display("FAIL R5/R6 [%s] byte writes: actual %0d expected %0d", tag, wr_cnt, exp_wr);
        end
        if (n == 0) begin
            vectors++;
            if (acc_seen) begin
                miscompares++;
                $display("FAIL R8 [%s] power/request activity: actual 1 expected 0", tag);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values while reset is still held.
        vectors++;
        if ({pwr_a_o, pwr_b_o, iso_o, burst_o, fuse_req_o, buf_we_o, done_o, err_o} != 8'b0010_0000) begin
            miscompares++;
            $display("FAIL R1 reset: actual %b expected 00100000",
                     {pwr_a_o, pwr_b_o, iso_o, burst_o, fuse_req_o, buf_we_o, done_o, err_o});
        end
        rst_n = 1;
        cmp_en = 1;
        repeat (2) @(posedge clk);
        run(16'h010, 4, 0, 2, 0, "R2 R4 R5 R7 normal");
        run(16'h7FE, 3, 1, 1, 0, "R3 burst and address wrap");
        run(16'h123, 2, 0, TMO - 1, 0, "R5 latency just under limit");
        run(16'h200, 3, 1, TMO, 0, "R6 timeout");
        repeat (5) step();                 // R10: error held while idle
        run(16'h300, 0, 0, 1, 0, "R8 R10 zero count clears error");
        run(16'h040, 2, 0, 3, 1, "R9 start while busy");
        run(16'h055, 1, 1, 4, 0, "R5 single byte");
        run(16'h060, 0, 1, 1, 0, "R8 zero count again");
        summary();
    end
endmodule